// File: doc/BRIEF.md
# Debug Authentication Gate

This block sits between a debugger's register-access port and the registers of a debug module. It keeps a challenge/response lock. While the lock is closed, a debugger may read anything, but it may write only the control register and the authentication-data register. Every other write is refused and never reaches the registers behind the gate. To open the lock, the debugger reads the 32-bit challenge and writes back that value plus a fixed secret of one. A wrong answer closes the lock and replaces the challenge.

Challenges are taken from a free-running 32-bit maximal-length shift register, which advances on every clock. A challenge is captured on system reset, on every module reset requested through the control register, and after every wrong answer. A configuration input removes the lock entirely. In that case the gate is transparent and the authentication register ignores writes.

Requests arrive one per cycle. The downstream write enable is combinational in the request cycle. The response (valid, accept flag, read data) is registered and comes one cycle later.

Top module: `dbg_auth_gate`

## Requirements
- R1: After the active-low reset, `authenticated_o` is 0 when `auth_required_i` is 1 and 1 when it is 0. `dm_active_o` is 0, and the challenge equals the seed 0x0000_0001.
- R2: Every request cycle produces `rsp_valid_o` high exactly one cycle later. A read of address 0x30 returns the current challenge on `rsp_rdata_o`.
- R3: With the lock closed or open, a write to 0x30 whose data equals challenge + 1 (modulo 2^32) makes `authenticated_o` 1 from the next cycle.
- R4: With authentication required, a write to 0x30 with any other data makes `authenticated_o` 0. It also replaces the challenge with the shift register's value in that request cycle.
- R5: When authentication is not required, writes to 0x30 change neither `authenticated_o` nor the challenge. All writes are accepted, and every write except one to 0x30 raises `ds_we_o`.
- R6: While not authenticated, a write to any address other than 0x10 and 0x30 is answered with `rsp_ok_o` = 0 and leaves `ds_we_o` low.
- R7: While not authenticated, a write to 0x10 is accepted and only its bit 0 (module active) is kept. `ds_we_o` stays low.
- R8: A write to 0x10 that changes module-active from 0 to 1 restarts the gate. Authentication returns to its reset value, and the challenge is recaptured from the shift register in that cycle.
- R9: Reads are always accepted. Address 0x11 returns `authenticated_o` in bit 7 and zeros elsewhere. Address 0x10 returns module-active in bit 0. Any other address except 0x30 returns 0.
- R10: The shift register starts from 0x0000_0001 and, each cycle, becomes {s[30:0], s[31]^s[21]^s[1]^s[0]}.
- R11: While authenticated, every write other than one to 0x30 is accepted and raises `ds_we_o` in its request cycle. Writes to 0x10 are included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auth_required_i | input | 1 | Lock enabled (static configuration) |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 7 | Register address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response for last cycle's request |
| rsp_ok_o | output | 1 | 1 = accepted, 0 = refused |
| rsp_rdata_o | output | 32 | Read data (0 for writes) |
| authenticated_o | output | 1 | Lock open / transparent |
| dm_active_o | output | 1 | Module-active bit of the control register |
| ds_we_o | output | 1 | Write enable to downstream registers |

## Verification
`ds_we_o` is combinational in the request cycle. The bench samples it 1 ns after driving inputs on a falling edge. Responses, status bits and challenge changes are due on the next rising edge. The bench samples them on the falling edge that follows, after one register stage. Expected challenges come from a shift-register model in the bench that is reset and clocked alongside the design, and is read at the moment each request is driven.

// File: rtl/dag_pkg.sv
package dag_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_OPEN   = 2'd1,
        ST_BYPASS = 2'd2
    } auth_state_e;

    typedef enum logic [1:0] {
        WK_NONE  = 2'd0,
        WK_CTRL  = 2'd1,
        WK_AUTH  = 2'd2,
        WK_OTHER = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/dag_lfsr.sv
module dag_lfsr #(
    parameter int             WIDTH = 32,
    parameter logic [WIDTH-1:0] TAPS  = 32'h8020_0003,
    parameter logic [WIDTH-1:0] SEED  = 32'h0000_0001
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] state_o
);
    logic [WIDTH-1:0] s_q;
    logic             fb;

    assign fb = ^(s_q & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEED;
        else        s_q <= {s_q[WIDTH-2:0], fb};
    end

    assign state_o = s_q;
endmodule

// File: rtl/dag_req_decode.sv
module dag_req_decode
    import dag_pkg::*;
#(
    parameter int                ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 7'h10,
    parameter logic [ADDR_W-1:0] ADDR_AUTH = 7'h30
) (
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    output wr_kind_e          kind_o
);
    always_comb begin
        if (!(valid_i && write_i))   kind_o = WK_NONE;
        else if (addr_i == ADDR_CTRL) kind_o = WK_CTRL;
        else if (addr_i == ADDR_AUTH) kind_o = WK_AUTH;
        else                          kind_o = WK_OTHER;
    end
endmodule

// File: rtl/dag_auth_fsm.sv
module dag_auth_fsm
    import dag_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] SECRET = 32'h0000_0001,
    parameter logic [DATA_W-1:0] SEED   = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auth_required_i,
    input  wr_kind_e          kind_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] lfsr_i,
    output logic              authenticated_o,
    output logic              dm_active_o,
    output logic [DATA_W-1:0] challenge_o,
    output logic              ds_we_o,
    output logic              wr_ok_o
);
    auth_state_e       state_q, state_d;
    logic [DATA_W-1:0] chal_q, chal_d;
    logic              act_q, act_d;
    logic [DATA_W-1:0] answer;
    logic              dm_restart;

    assign answer     = chal_q + SECRET;
    assign dm_restart = (kind_i == WK_CTRL) && wdata_i[0] && !act_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= auth_required_i ? ST_LOCKED : ST_BYPASS;
            chal_q  <= SEED;
            act_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            chal_q  <= chal_d;
            act_q   <= act_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        chal_d  = chal_q;
        act_d   = (kind_i == WK_CTRL) ? wdata_i[0] : act_q;
        unique case (state_q)
            ST_LOCKED, ST_OPEN: begin
                if (kind_i == WK_AUTH) begin
                    if (wdata_i == answer) begin
                        state_d = ST_OPEN;
                    end else begin
                        state_d = ST_LOCKED;
                        chal_d  = lfsr_i;
                    end
                end
            end
            ST_BYPASS: state_d = ST_BYPASS;
            default:   state_d = ST_LOCKED;
        endcase
        if (dm_restart) begin
            state_d = auth_required_i ? ST_LOCKED : ST_BYPASS;
            chal_d  = lfsr_i;
        end
    end

    // outputs
    always_comb begin
        authenticated_o = (state_q != ST_LOCKED);
        ds_we_o         = authenticated_o && (kind_i == WK_OTHER || kind_i == WK_CTRL);
        wr_ok_o         = (kind_i == WK_OTHER) ? authenticated_o : 1'b1;
    end

    assign dm_active_o = act_q;
    assign challenge_o = chal_q;
endmodule

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate
    import dag_pkg::*;
#(
    parameter int                ADDR_W    = 7,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 7'h10,
    parameter logic [ADDR_W-1:0] ADDR_STAT = 7'h11,
    parameter logic [ADDR_W-1:0] ADDR_AUTH = 7'h30,
    parameter int                STAT_BIT  = 7,
    parameter logic [DATA_W-1:0] SEED      = 32'h0000_0001,
    parameter logic [DATA_W-1:0] TAPS      = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auth_required_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              rsp_valid_o,
    output logic              rsp_ok_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              authenticated_o,
    output logic              dm_active_o,
    output logic              ds_we_o
);
    localparam logic [DATA_W-1:0] SECRET = DATA_W'(1);

    wr_kind_e          kind_w;
    logic [DATA_W-1:0] lfsr_w;
    logic [DATA_W-1:0] challenge_w;
    logic              wr_ok_w;
    logic [DATA_W-1:0] rd_mux;

    dag_lfsr #(.WIDTH(DATA_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .state_o(lfsr_w)
    );

    dag_req_decode #(.ADDR_W(ADDR_W), .ADDR_CTRL(ADDR_CTRL), .ADDR_AUTH(ADDR_AUTH)) u_dec (
        .valid_i(req_valid_i), .write_i(req_write_i), .addr_i(req_addr_i), .kind_o(kind_w)
    );

    dag_auth_fsm #(.DATA_W(DATA_W), .SECRET(SECRET), .SEED(SEED)) u_fsm (
        .clk(clk), .rst_n(rst_n), .auth_required_i(auth_required_i),
        .kind_i(kind_w), .wdata_i(req_wdata_i), .lfsr_i(lfsr_w),
        .authenticated_o(authenticated_o), .dm_active_o(dm_active_o),
        .challenge_o(challenge_w), .ds_we_o(ds_we_o), .wr_ok_o(wr_ok_w)
    );

    always_comb begin
        rd_mux = '0;
        if (req_addr_i == ADDR_CTRL)      rd_mux[0]        = dm_active_o;
        else if (req_addr_i == ADDR_STAT) rd_mux[STAT_BIT] = authenticated_o;
        else if (req_addr_i == ADDR_AUTH) rd_mux           = challenge_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_ok_o    <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= req_valid_i;
            rsp_ok_o    <= req_valid_i && (req_write_i ? wr_ok_w : 1'b1);
            rsp_rdata_o <= (req_valid_i && !req_write_i) ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/dag_checker.sv
module dag_checker #(
    parameter int                ADDR_W    = 7,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 7'h10,
    parameter logic [ADDR_W-1:0] ADDR_AUTH = 7'h30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              auth_required_i,
    input logic              req_valid_i,
    input logic              req_write_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic [DATA_W-1:0] req_wdata_i,
    input logic              rsp_valid_o,
    input logic              rsp_ok_o,
    input logic              authenticated_o,
    input logic              ds_we_o,
    input logic [DATA_W-1:0] chal_i
);
    logic wr, wr_other, wr_auth, good;
    assign wr       = req_valid_i && req_write_i;
    assign wr_auth  = wr && (req_addr_i == ADDR_AUTH);
    assign wr_other = wr && (req_addr_i != ADDR_AUTH) && (req_addr_i != ADDR_CTRL);
    assign good     = (req_wdata_i == chal_i + DATA_W'(1));

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o); // R2
    AST_LOCKED_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_other && !authenticated_o) |=> (rsp_valid_o && !rsp_ok_o)); // R6
    AST_LOCKED_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_other && !authenticated_o) |-> !ds_we_o); // R6
    AST_GOOD_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_auth && auth_required_i && good) |=> authenticated_o); // R3
    AST_BAD_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_auth && auth_required_i && !good) |=> (!authenticated_o && chal_i != $past(chal_i))); // R4
    AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!auth_required_i && authenticated_o) |=> authenticated_o); // R5
    AST_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i) |=> rsp_ok_o); // R9
endmodule

bind dbg_auth_gate dag_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_CTRL(ADDR_CTRL), .ADDR_AUTH(ADDR_AUTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .auth_required_i(auth_required_i),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o), .rsp_ok_o(rsp_ok_o),
    .authenticated_o(authenticated_o), .ds_we_o(ds_we_o), .chal_i(challenge_w)
);

// File: tb/dbg_auth_gate_bench.sv
`timescale 1ns/1ps
module dbg_auth_gate_bench;
    localparam logic [6:0]  A_CTRL = 7'h10;
    localparam logic [6:0]  A_STAT = 7'h11;
    localparam logic [6:0]  A_AUTH = 7'h30;
    localparam logic [31:0] SEED   = 32'h0000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        auth_req = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_ok, authenticated, dm_active, ds_we;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    logic        got_ds, got_valid, got_ok;
    logic [31:0] got_rd, cap, chal, m_lfsr;

    always #2 clk = ~clk;

    dbg_auth_gate u_dbg_auth_gate (
        .clk(clk), .rst_n(rst_n), .auth_required_i(auth_req),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_ok_o(rsp_ok),
        .rsp_rdata_o(rsp_rdata), .authenticated_o(authenticated),
        .dm_active_o(dm_active), .ds_we_o(ds_we)
    );

    // R10 shift-register model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_lfsr <= SEED;
        else        m_lfsr <= {m_lfsr[30:0], m_lfsr[31] ^ m_lfsr[21] ^ m_lfsr[1] ^ m_lfsr[0]};
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic txn(input logic w, input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        #1;
        got_ds = ds_we;
        cap    = m_lfsr;
        @(negedge clk);
        got_valid = rsp_valid; got_ok = rsp_ok; got_rd = rsp_rdata;
        req_valid = 1'b0; req_write = 1'b0;
        chk("R2 rsp_valid", {31'b0, got_valid}, 32'd1);
    endtask

    task automatic do_reset(input logic need);
        @(negedge clk);
        rst_n = 1'b0; auth_req = need;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic authenticate();
        txn(1'b0, A_AUTH, 32'h0);
        txn(1'b1, A_AUTH, got_rd + 32'd1);
        chk("R3 open after good answer", {31'b0, authenticated}, 32'd1);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset(1'b1);
        chk("R1 locked at reset", {31'b0, authenticated}, 32'd0);
        chk("R1 dm_active reset", {31'b0, dm_active}, 32'd0);
        txn(1'b0, A_AUTH, 32'h0);
        chk("R1 seed challenge", got_rd, SEED);
        txn(1'b0, A_STAT, 32'h0);
        chk("R9 status locked", got_rd, 32'h0);
        chk("R9 read ok", {31'b0, got_ok}, 32'd1);

        // R7/R8: control write while locked, halt bits set
        txn(1'b1, A_CTRL, 32'h8000_0001);
        chal = cap;
        chk("R7 ctrl ok", {31'b0, got_ok}, 32'd1);
        chk("R7 ctrl no ds", {31'b0, got_ds}, 32'd0);
        txn(1'b0, A_CTRL, 32'h0);
        chk("R7 only active bit kept", got_rd, 32'h1);
        txn(1'b0, A_AUTH, 32'h0);
        chk("R8 challenge recaptured", got_rd, chal);
        chk("R8 still locked", {31'b0, authenticated}, 32'd0);

        // R6 sweep over every address while locked
        for (int a = 0; a < 128; a++) begin
            if (a == A_CTRL || a == A_AUTH) continue;
            txn(1'b1, 7'(a), 32'hA5A5_0000 | a);
            chk($sformatf("R6 refuse addr %0h", a), {31'b0, got_ok}, 32'd0);
            chk($sformatf("R6 no ds addr %0h", a), {31'b0, got_ds}, 32'd0);
        end
        chk("R6 still locked", {31'b0, authenticated}, 32'd0);

        // R4 wrong answers
        for (int k = 0; k < 4; k++) begin
            logic [31:0] bad;
            txn(1'b0, A_AUTH, 32'h0);
            chal = got_rd;
            bad = (k == 0) ? chal : (k == 1) ? chal + 32'd2 :
                  (k == 2) ? ~(chal + 32'd1) : (chal + 32'd1) ^ 32'h8000_0000;
            txn(1'b1, A_AUTH, bad);
            chal = cap;
            chk("R4 bad answer ok flag", {31'b0, got_ok}, 32'd1);
            chk("R4 locked after bad", {31'b0, authenticated}, 32'd0);
            txn(1'b0, A_AUTH, 32'h0);
            chk("R4 new challenge", got_rd, chal);
        end

        authenticate();
        txn(1'b0, A_STAT, 32'h0);
        chk("R9 status bit7", got_rd, 32'h0000_0080);

        // R11 sweep while open
        for (int a = 0; a < 128; a++) begin
            if (a == A_AUTH) continue;
            txn(1'b1, 7'(a), 32'h0000_0001 | (a << 8));
            chk($sformatf("R11 ok addr %0h", a), {31'b0, got_ok}, 32'd1);
            chk($sformatf("R11 ds addr %0h", a), {31'b0, got_ds}, 32'd1);
        end
        txn(1'b0, 7'h05, 32'h0);
        chk("R9 other read zero", got_rd, 32'h0);

        // R4 wrong answer from open state
        txn(1'b0, A_AUTH, 32'h0);
        txn(1'b1, A_AUTH, got_rd + 32'd7);
        chal = cap;
        chk("R4 open drops", {31'b0, authenticated}, 32'd0);
        txn(1'b0, A_AUTH, 32'h0);
        chk("R4 challenge after drop", got_rd, chal);

        // R8 restart from open
        authenticate();
        txn(1'b1, A_CTRL, 32'h0);
        chk("R11 ctrl clear passes", {31'b0, got_ds}, 32'd1);
        chk("R8 no restart on clear", {31'b0, authenticated}, 32'd1);
        txn(1'b1, A_CTRL, 32'h1);
        chal = cap;
        chk("R8 restart relocks", {31'b0, authenticated}, 32'd0);
        txn(1'b0, A_AUTH, 32'h0);
        chk("R8 restart challenge", got_rd, chal);
        txn(1'b1, A_CTRL, 32'h1);
        txn(1'b0, A_AUTH, 32'h0);
        chk("R8 1->1 keeps challenge", got_rd, chal);

        // R1/R5 bypass configuration
        do_reset(1'b0);
        chk("R1 bypass open", {31'b0, authenticated}, 32'd1);
        txn(1'b1, A_CTRL, 32'h1);
        chal = cap;
        for (int a = 0; a < 128; a++) begin
            txn(1'b1, 7'(a), 32'h0000_0001 | (a << 12));
            chk($sformatf("R5 ok addr %0h", a), {31'b0, got_ok}, 32'd1);
            chk($sformatf("R5 ds addr %0h", a), {31'b0, got_ds}, (a == A_AUTH) ? 32'd0 : 32'd1);
        end
        txn(1'b1, A_AUTH, chal + 32'd3);
        chk("R5 still open", {31'b0, authenticated}, 32'd1);
        txn(1'b0, A_AUTH, 32'h0);
        chk("R5 challenge untouched", got_rd, chal);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule